// File: doc/BRIEF.md
# Configuration register access controller

This block is the device-side control logic for the 16-bit configuration register of a pseudo-static RAM. It sees each host access as one sampled event per clock: a strobe, a read/write flag, a flag that says the write was chip-enable controlled, the 22-bit address and the 16-bit write data. It also samples the level of the active-low sleep pin. The register can be loaded in two ways. The first is through the sleep pin: the pin falls, and the write that follows carries the new value on its address lines. The second is a software unlock: a fixed pattern of accesses to the highest address, after which the fourth access either loads the register from the data bus or returns the register on the read data output.

The block also decides which low-power mode the sleep pin requests. That choice depends on the sleep-mode bit of the register and on whether a software load has ever completed. A completed software load moves control of partial-array refresh away from the pin. This change stays in place until reset. The memory array, the refresh timing and the analog pin timing are outside this block.

Top module: `cfgreg_ctrl`

## Requirements
- R1: After reset the register holds 0070h, read data is 0000h, no software load is recorded, and with the sleep pin high both sleep outputs are 0.
- R2: The sleep pin counts as falling when it was sampled high on one clock and low on the next. The first access after that fall is claimed by the pin path. If it is a write, the register takes address bits [15:0] masked with 00F7h. If it is a read, the register is unchanged and read data is 0000h. A claimed access returns the software sequence tracker to idle.
- R3: Four accesses at address 3FFFFFh, in the order read, read, chip-enable-controlled write of 0000h, read, put the register value on read data in the cycle after the fourth read. Every other read returns 0000h.
- R4: Four accesses at address 3FFFFFh, in the order read, read, chip-enable-controlled write of 0000h, write, load the register with the fourth write's data bits [7:5] and [2:0]. Bit 4, the sleep-mode bit, keeps its previous value.
- R5: Bit 3 and bits [15:8] of the register, and of the read data, are always 0.
- R6: If the third access is a write that is not chip-enable controlled, or a write whose data is not 0000h, the sequence aborts. The next access at the top address does not touch the register.
- R7: A third consecutive read of 3FFFFFh cancels the sequence. No new sequence can start until a read of some other address is seen. Writes and further top-address reads do not release this lock.
- R8: An access to any address other than 3FFFFFh, or an access of the wrong kind for the current step, returns the tracker to idle. The register does not change.
- R9: Until a software load has completed: with the sleep pin low, par_active equals bit 4 and deep_pd_req equals its inverse; with the pin high, both are 0. Both outputs follow the pin level one clock after it is sampled.
- R10: Once a software load has completed, par_active equals bit 4 whatever the pin level, and deep_pd_req is 1 only while the pin is low and bit 4 is 0. A sequence that only reads does not cause this change. Only reset undoes it.
- R11: After a software load, the pin path still loads the register, and that value changes bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One access event this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_ce_ctrl | input | 1 | The write was chip-enable controlled |
| acc_addr | input | 22 | Access address |
| acc_wdata | input | 16 | Write data |
| sleep_n | input | 1 | Sleep pin level, active low |
| cfg_value | output | 16 | Current configuration register |
| rd_data | output | 16 | Read data of the last read access |
| par_active | output | 1 | Partial-array refresh enabled |
| deep_pd_req | output | 1 | Deep power-down requested |

## Verification
An error in the tracker state can be seen at the port one clock after the fourth access of a sequence. The register either takes a load it should have refused, or misses one it should have taken; a fetch shows up the same way on rd_data. A stale pin-arm flag or an ownership flag set at the wrong time shows up on par_active or deep_pd_req in the first cycle after the pin moves. The bench therefore samples the register and both sleep outputs after every pin edge and after every sequence, as well as after each access that might abort one.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

    // step tracker for the software unlock pattern
    typedef enum logic [2:0] {
        SEQ_IDLE = 3'd0,   // nothing seen
        SEQ_RD1  = 3'd1,   // one top-address read
        SEQ_RD2  = 3'd2,   // two top-address reads
        SEQ_UNLK = 3'd3,   // unlock write accepted, next top access acts on register
        SEQ_HOLD = 3'd4    // cancelled by third read, waits for another address read
    } seq_state_e;

endpackage

// File: rtl/cfgreg_seq_tracker.sv
module cfgreg_seq_tracker
    import cfgreg_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_ce_ctrl,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              pin_claim,
    output logic              sw_load,
    output logic              sw_fetch
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        seq_state_e state;
    } trk_t;

    trk_t trk_d, trk_q;
    logic at_top, is_rd, unlock_ok;

    always_comb begin
        at_top    = (acc_addr == TOP_ADDR);
        is_rd     = acc_valid && !acc_write;
        unlock_ok = acc_write && acc_ce_ctrl && (acc_wdata == '0);
        trk_d     = trk_q;
        sw_load   = 1'b0;
        sw_fetch  = 1'b0;
        if (acc_valid) begin
            if (pin_claim) begin
                trk_d.state = SEQ_IDLE;
            end else begin
                case (trk_q.state)
                    SEQ_IDLE: trk_d.state = (is_rd && at_top) ? SEQ_RD1 : SEQ_IDLE;
                    SEQ_RD1:  trk_d.state = (is_rd && at_top) ? SEQ_RD2 : SEQ_IDLE;
                    SEQ_RD2: begin
                        if (is_rd && at_top)          trk_d.state = SEQ_HOLD;
                        else if (at_top && unlock_ok) trk_d.state = SEQ_UNLK;
                        else                          trk_d.state = SEQ_IDLE;
                    end
                    SEQ_UNLK: begin
                        if (at_top) begin
                            sw_load  = acc_write;
                            sw_fetch = !acc_write;
                        end
                        trk_d.state = SEQ_IDLE;
                    end
                    SEQ_HOLD: trk_d.state = (is_rd && !at_top) ? SEQ_IDLE : SEQ_HOLD;
                    default:  trk_d.state = SEQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '{state: SEQ_IDLE};
        else        trk_q <= trk_d;
    end

    // R7
    hold_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.state == SEQ_HOLD && acc_valid && at_top && !pin_claim)
        |=> (trk_q.state == SEQ_HOLD));

    // R6
    abort_step3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.state == SEQ_RD2 && acc_valid && acc_write && !acc_ce_ctrl && !pin_claim)
        |=> (trk_q.state == SEQ_IDLE));

endmodule

// File: rtl/cfgreg_store.sv
module cfgreg_store #(
    parameter int              ADDR_W    = 22,
    parameter int              DATA_W    = 16,
    parameter logic [15:0]     RESET_VAL = 16'h0070,
    parameter logic [15:0]     KEEP_MASK = 16'h00F7,
    parameter int              SLEEP_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              sleep_n,
    input  logic              sw_load,
    input  logic              sw_fetch,
    output logic              pin_claim,
    output logic [DATA_W-1:0] cfg_value,
    output logic [DATA_W-1:0] rd_data,
    output logic              sw_owned,
    output logic              pin_n_q
);
    localparam logic [DATA_W-1:0] MASK  = KEEP_MASK[DATA_W-1:0];
    localparam logic [DATA_W-1:0] SMASK = DATA_W'(1) << SLEEP_BIT;
    localparam logic [DATA_W-1:0] SWMASK = MASK & ~SMASK;

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] rd;
        logic              owned;
        logic              pin;
        logic              armed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        pin_claim = st_q.armed && acc_valid;
        st_d      = st_q;
        st_d.pin  = sleep_n;
        if (st_q.pin && !sleep_n)     st_d.armed = 1'b1;
        else if (acc_valid || sleep_n) st_d.armed = 1'b0;

        if (pin_claim && acc_write) begin
            st_d.cfg = acc_addr[DATA_W-1:0] & MASK;
        end else if (sw_load) begin
            st_d.cfg   = (acc_wdata & SWMASK) | (st_q.cfg & SMASK);
            st_d.owned = 1'b1;
        end

        if (acc_valid && !acc_write)
            st_d.rd = sw_fetch ? st_q.cfg : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cfg: RESET_VAL[DATA_W-1:0], rd: '0, owned: 1'b0,
                              pin: 1'b1, armed: 1'b0};
        else        st_q <= st_d;
    end

    assign cfg_value = st_q.cfg;
    assign rd_data   = st_q.rd;
    assign sw_owned  = st_q.owned;
    assign pin_n_q   = st_q.pin;

    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cfg & ~MASK) == '0) && ((st_q.rd & ~MASK) == '0));

    // R4
    sw_keeps_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_load |=> (st_q.cfg[SLEEP_BIT] == $past(st_q.cfg[SLEEP_BIT])));

    // R10
    owned_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.owned |=> st_q.owned);

    // R2
    pin_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_claim && !acc_write) |=> $stable(st_q.cfg));

endmodule

// File: rtl/cfgreg_sleep_ctrl.sv
module cfgreg_sleep_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_q,
    input  logic sleep_bit,
    input  logic sw_owned,
    output logic par_active,
    output logic deep_pd_req
);
    logic pin_low;

    always_comb begin
        pin_low     = !pin_n_q;
        par_active  = sw_owned ? sleep_bit : (pin_low && sleep_bit);
        deep_pd_req = pin_low && !sleep_bit;
    end

    // R9
    modes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_active && deep_pd_req));

endmodule

// File: rtl/cfgreg_ctrl.sv
module cfgreg_ctrl #(
    parameter int          ADDR_W    = 22,
    parameter int          DATA_W    = 16,
    parameter logic [15:0] RESET_VAL = 16'h0070,
    parameter logic [15:0] KEEP_MASK = 16'h00F7,
    parameter int          SLEEP_BIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_ce_ctrl,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              sleep_n,
    output logic [DATA_W-1:0] cfg_value,
    output logic [DATA_W-1:0] rd_data,
    output logic              par_active,
    output logic              deep_pd_req
);
    logic pin_claim, sw_load, sw_fetch, sw_owned, pin_n_q;

    cfgreg_seq_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_trk (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_ce_ctrl(acc_ce_ctrl), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .pin_claim(pin_claim), .sw_load(sw_load), .sw_fetch(sw_fetch)
    );

    cfgreg_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_VAL(RESET_VAL),
                   .KEEP_MASK(KEEP_MASK), .SLEEP_BIT(SLEEP_BIT)) i_store (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .sleep_n(sleep_n),
        .sw_load(sw_load), .sw_fetch(sw_fetch), .pin_claim(pin_claim),
        .cfg_value(cfg_value), .rd_data(rd_data), .sw_owned(sw_owned),
        .pin_n_q(pin_n_q)
    );

    cfgreg_sleep_ctrl i_sleep (
        .clk(clk), .rst_n(rst_n), .pin_n_q(pin_n_q),
        .sleep_bit(cfg_value[SLEEP_BIT]), .sw_owned(sw_owned),
        .par_active(par_active), .deep_pd_req(deep_pd_req)
    );

    // R2
    one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pin_claim && (sw_load || sw_fetch)));

    // R10
    owned_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_owned && pin_n_q) |-> (par_active == cfg_value[SLEEP_BIT]) && !deep_pd_req);

endmodule

// File: tb/test_cfgreg_ctrl.sv
`timescale 1ns/1ps
module test_cfgreg_ctrl;
    localparam logic [21:0] TOP = 22'h3FFFFF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_valid = 0, acc_write = 0, acc_ce_ctrl = 0, sleep_n = 1;
    logic [21:0] acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] cfg_value, rd_data;
    logic par_active, deep_pd_req;

    int checks = 0, errors = 0;
    logic [15:0] exp_cfg = 16'h0070;
    logic exp_own = 1'b0;

    always #2.5 clk = ~clk;

    cfgreg_ctrl i_cfgreg_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_ce_ctrl(acc_ce_ctrl), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .sleep_n(sleep_n), .cfg_value(cfg_value), .rd_data(rd_data),
        .par_active(par_active), .deep_pd_req(deep_pd_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_sleep(input string req);
        logic low, e_par, e_dpd;
        low   = !sleep_n;
        e_par = exp_own ? exp_cfg[4] : (low && exp_cfg[4]);
        e_dpd = low && !exp_cfg[4];
        chk({req, " par"}, {15'd0, par_active}, {15'd0, e_par});
        chk({req, " dpd"}, {15'd0, deep_pd_req}, {15'd0, e_dpd});
    endtask

    task automatic acc(input logic w, input logic ce, input logic [21:0] a, input logic [15:0] d);
        @(negedge clk);
        acc_valid = 1; acc_write = w; acc_ce_ctrl = ce; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 0;
    endtask

    task automatic pin(input logic v);
        @(negedge clk);
        sleep_n = v;
        @(negedge clk);
    endtask

    task automatic unlock();
        acc(0, 0, TOP, 16'h0000);
        acc(0, 0, TOP, 16'h0000);
        acc(1, 1, TOP, 16'h0000);
    endtask

    task automatic sw_write(input logic [15:0] d);
        unlock();
        acc(1, 1, TOP, d);
        exp_cfg = (d & 16'h00E7) | (exp_cfg & 16'h0010);
        exp_own = 1'b1;
    endtask

    task automatic pin_load(input logic [21:0] a);
        pin(1); pin(0);
        acc(1, 0, a, 16'hFFFF);
        exp_cfg = a[15:0] & 16'h00F7;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cfg", cfg_value, 16'h0070);
        chk("R1 rd", rd_data, 16'h0000);
        chk_sleep("R1");

        // R3 read-only software sequence
        acc(0, 0, TOP, 0);
        chk("R3 plain read", rd_data, 16'h0000);
        acc(0, 0, TOP, 0);
        acc(1, 1, TOP, 0);
        acc(0, 0, TOP, 0);
        chk("R3 fetch", rd_data, 16'h0070);
        chk("R3 cfg kept", cfg_value, 16'h0070);

        // R2 R9 pin load sweep before any software load
        for (int i = 0; i < 256; i++) begin
            pin_load({6'h2B, 8'(i * 7 + 3), 8'(i)});
            chk("R2 pin load", cfg_value, exp_cfg);
            chk_sleep("R9 pin low");
        end
        pin(1);
        chk_sleep("R9 pin high");

        // R2 pin-claimed read leaves register, does not count as sequence step
        pin_load(22'h000010);
        pin(1); pin(0);
        acc(0, 1, TOP, 0);
        chk("R2 pin read cfg", cfg_value, exp_cfg);
        chk("R2 pin read rd", rd_data, 16'h0000);
        acc(0, 0, TOP, 0);
        acc(1, 1, TOP, 0);
        acc(1, 1, TOP, 16'h00E7);
        chk("R2 claimed read not counted", cfg_value, exp_cfg);
        // R10 read-only sequence did not move pin control
        pin(1);
        chk_sleep("R10 no owner yet");

        // R4 R5 software load sweep
        for (int i = 0; i < 256; i++) begin
            sw_write({~8'(i), 8'(i)});
            chk("R4 sw load", cfg_value, exp_cfg);
            chk_sleep("R10 owned");
        end
        unlock();
        acc(0, 0, TOP, 0);
        chk("R5 fetch masked", rd_data, exp_cfg);

        // R6 non-CE-controlled step three aborts
        sw_write(16'h0001);
        unlock_nce();
        acc(1, 1, TOP, 16'h0006);
        chk("R6 non-ce abort", cfg_value, exp_cfg);
        acc(0, 0, TOP, 0); acc(0, 0, TOP, 0);
        acc(1, 1, TOP, 16'h0001);
        acc(1, 1, TOP, 16'h0006);
        chk("R6 nonzero data abort", cfg_value, exp_cfg);

        // R7 third read cancels and locks
        acc(0, 0, TOP, 0); acc(0, 0, TOP, 0); acc(0, 0, TOP, 0);
        acc(1, 1, TOP, 0);
        acc(1, 1, TOP, 16'h0002);
        chk("R7 cancel", cfg_value, exp_cfg);
        acc(1, 1, 22'h000123, 16'h0000);
        unlock();
        acc(1, 1, TOP, 16'h0003);
        chk("R7 still locked", cfg_value, exp_cfg);
        acc(0, 0, 22'h000123, 0);
        sw_write(16'h0003);
        chk("R7 released", cfg_value, exp_cfg);

        // R8 interrupted or out-of-order patterns
        acc(0, 0, TOP, 0); acc(0, 0, 22'h1FFFFF, 0); acc(0, 0, TOP, 0);
        acc(1, 1, TOP, 0); acc(1, 1, TOP, 16'h0005);
        chk("R8 other addr", cfg_value, exp_cfg);
        acc(0, 0, TOP, 0); acc(1, 1, TOP, 0); acc(1, 1, TOP, 0);
        acc(1, 1, TOP, 16'h0005);
        chk("R8 out of order", cfg_value, exp_cfg);
        unlock();
        acc(1, 1, 22'h3FFFFE, 16'h0005);
        acc(1, 1, TOP, 16'h0005);
        chk("R8 step four off top", cfg_value, exp_cfg);

        // R11 pin path after software load, with R10 mode rules
        pin_load(22'h000005);
        chk("R11 pin load", cfg_value, 16'h0005);
        chk_sleep("R11 low dpd");
        pin(1);
        chk_sleep("R11 high");
        pin_load(22'h000017);
        chk("R11 bit4 set", cfg_value, 16'h0017);
        chk_sleep("R10 low par");
        pin(1);
        chk_sleep("R10 high par");

        // R1 reset clears ownership
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        exp_cfg = 16'h0070; exp_own = 1'b0;
        chk("R1 re-reset cfg", cfg_value, 16'h0070);
        chk_sleep("R1 re-reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic unlock_nce();
        acc(0, 0, TOP, 0);
        acc(0, 0, TOP, 0);
        acc(1, 0, TOP, 0);
    endtask

endmodule